// File: doc/BRIEF.md
# UART Line Break and Idle Detector

This block watches a single asynchronous serial line and times how long it sits at each level, using the duration of one complete character frame as the yardstick. The frame duration comes from the live format settings: clocks per bit, number of data bits, whether a parity bit is present, and a stop length that may be zero, a half, one or one and a half bits. The block rounds the result up to whole clocks. A low stretch that lasts at least one frame duration is reported as a break when the line returns high. A high stretch produces an idle pulse each time another full frame duration has gone by.

The line passes through an optional polarity inversion and a short synchronizer before it is timed. Both outputs are registered single-cycle pulses. A companion receiver can report the end of each received frame together with the number of clocks since that frame's start edge. The idle timer then lines up with the frame grid: the next idle pulse falls one frame duration after the point where the received frame would have ended. Format inputs are expected to change only while reset is held.

Top module: `uart_line_watch`

## Requirements
- R1: While reset is held both pulse outputs are low. With the line idle-high through reset, the first idle pulse appears `L` clock edges after the last edge that samples reset high.
- R2: The frame duration `L` in clocks is ceil(clks_per_bit × (1 + data_bits + parity_en + S)). S is chosen by `stop_sel_i`: 0 gives 0, 1 gives 0.5, 2 gives 1 and 3 gives 1.5.
- R3: Suppose the line is low for N consecutive sampling edges, with N ≥ L, and is first sampled high again at edge k. Then `break_o` is high for the single cycle after edge k+2.
- R4: A low period of N < L sampling edges produces no break pulse.
- R5: Every falling edge restarts low-period timing. Two low periods, each shorter than L, separated by a high period as short as one clock, produce no break even when together they reach L.
- R6: The low-period timer saturates instead of wrapping. A low period longer than 2^(clks_per_bit width + 5) clocks still produces its break pulse.
- R7: If the line is first sampled high at edge k and stays high, `idle_o` pulses after edges k+1+L, k+1+2L, and so on, once every L edges.
- R8: Any low sample cancels idle timing. A high period shorter than L produces no idle pulse. The next high period starts a fresh count of L.
- R9: With `invert_i` high the line is complemented before timing, so a held-low pin is idle and a high pin stretch is a break.
- R10: When `frame_done_i` is sampled high at edge h with `frame_age_i` = a while the timed level is high, the next idle pulse comes after edge h+max(1, 2L−a) and then every L edges. A regular idle pulse that would have fallen on edge h is dropped.
- R11: `frame_done_i` sampled while the timed level is low has no effect on idle timing.
- R12: `break_o` and `idle_o` are never high in the same cycle. With L ≥ 2, neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial line |
| invert_i | input | 1 | Complement the line before timing |
| clks_per_bit_i | input | CPB_W | Clocks per bit |
| data_bits_i | input | 4 | Data bits per frame (5 to 9) |
| parity_en_i | input | 1 | One parity bit is present |
| stop_sel_i | input | 2 | Stop length code (0, 0.5, 1, 1.5 bits) |
| frame_done_i | input | 1 | Receiver reports the end of a frame |
| frame_age_i | input | CPB_W+6 | Clocks since that frame's start edge |
| break_o | output | 1 | Break pulse |
| idle_o | output | 1 | Idle pulse |

## Verification
A wrong frame duration shows up as a break pulse that appears or goes missing at the boundary length L, and as idle pulses whose spacing drifts from L. These errors are visible within one frame time. A low-period timer that fails to restart on a falling edge, or that wraps, turns into a spurious or lost break at the next rising edge. A stale idle countdown, caused by a missed cancellation or by a frame-end hint that is ignored or misapplied, moves the next idle pulse away from the cycle predicted from L and the age value. Every pulse is therefore compared against the exact clock edge the requirements give for it.

// File: rtl/uart_lw_pkg.sv
package uart_lw_pkg;

  typedef enum logic [1:0] {
    STOP_NONE     = 2'd0,
    STOP_HALF     = 2'd1,
    STOP_ONE      = 2'd2,
    STOP_ONE_HALF = 2'd3
  } stop_len_e;

  localparam int HALF_W = 6;

  // Frame span counted in half-bit units: start, data and parity bits count
  // two halves each; the stop code already equals its own half count.
  function automatic logic [HALF_W-1:0] frame_halves(
      input logic [3:0] data_bits,
      input logic       parity_en,
      input stop_len_e  stop_len);
    logic [HALF_W-1:0] whole;
    whole = HALF_W'(data_bits) + HALF_W'(1) + HALF_W'(parity_en);
    return HALF_W'(whole << 1) + HALF_W'(stop_len);
  endfunction

endpackage

// File: rtl/uart_lw_framelen.sv
module uart_lw_framelen
  import uart_lw_pkg::*;
#(
  parameter int CPB_W = 8,
  parameter int CNT_W = CPB_W + 5
) (
  input  logic             clk,
  input  logic [CPB_W-1:0] cpb_i,
  input  logic [3:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_sel_i,
  output logic [CNT_W-1:0] frame_len_o
);

  localparam int PROD_W = CPB_W + HALF_W;

  logic [HALF_W-1:0] halves;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rounded;

  assign halves  = frame_halves(data_bits_i, parity_en_i, stop_len_e'(stop_sel_i));
  assign prod    = PROD_W'(cpb_i) * PROD_W'(halves);
  // Half-bit product divided by two, rounded up.
  assign rounded = (prod + PROD_W'(1)) >> 1;

  // Format inputs are quasi-static; one pipeline register keeps the
  // multiplier out of the timer compare paths.
  always_ff @(posedge clk) begin
    frame_len_o <= rounded[CNT_W-1:0];
  end

endmodule

// File: rtl/uart_lw_level.sv
module uart_lw_level #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic invert_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic pol;
  logic lvl_q;
  logic prev_q;

  assign pol = line_i ^ invert_i;

  generate
    if (SYNC_STAGES <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= pol;
      end
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[SYNC_STAGES-2:0], pol};
      end
      assign lvl_q = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl_q;
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

endmodule

// File: rtl/uart_lw_break.sv
module uart_lw_break #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic             break_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      break_o <= 1'b0;
    end else begin
      break_o <= rise_i && (low_cnt >= frame_len_i);
      if (fall_i)
        low_cnt <= CNT_W'(1);
      else if (!lvl_i && low_cnt != CNT_MAX)
        low_cnt <= low_cnt + CNT_W'(1);
    end
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!lvl_i && !fall_i) |=> (low_cnt >= $past(low_cnt)));

  // R12
  brk_single_chk: assert property (@(posedge clk) disable iff (rst)
    break_o |=> !break_o);

endmodule

// File: rtl/uart_lw_idle.sv
module uart_lw_idle #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic             hint_i,
  input  logic [CNT_W:0]   age_i,
  output logic             idle_o
);

  localparam int REM_W = CNT_W + 1;

  logic             running;
  logic [REM_W-1:0] remain;
  logic [REM_W-1:0] span;
  logic [REM_W-1:0] twice;
  logic [REM_W-1:0] first_load;
  logic [REM_W-1:0] hint_load;

  assign span       = {1'b0, frame_len_i};
  assign twice      = {frame_len_i, 1'b0};
  assign first_load = (span > REM_W'(1)) ? span - REM_W'(1) : REM_W'(1);
  // Next pulse sits one frame after the received frame's nominal end.
  assign hint_load  = (age_i >= twice) ? REM_W'(1) : twice - age_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      remain  <= '0;
      idle_o  <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (!lvl_i) begin
        running <= 1'b0;
      end else if (hint_i) begin
        running <= 1'b1;
        remain  <= hint_load;
      end else if (!running) begin
        running <= 1'b1;
        remain  <= first_load;
      end else if (remain == REM_W'(1)) begin
        idle_o <= 1'b1;
        remain <= span;
      end else begin
        remain <= remain - REM_W'(1);
      end
    end
  end

  // R7
  remain_live_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (remain != '0));

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> $past(lvl_i));

  // R12
  idle_single_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_o && frame_len_i > CNT_W'(1)) |=> !idle_o);

endmodule

// File: rtl/uart_line_watch.sv
module uart_line_watch #(
  parameter int CPB_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = CPB_W + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             invert_i,
  input  logic [CPB_W-1:0] clks_per_bit_i,
  input  logic [3:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_sel_i,
  input  logic             frame_done_i,
  input  logic [CNT_W:0]   frame_age_i,
  output logic             break_o,
  output logic             idle_o
);

  logic [CNT_W-1:0] frame_len;
  logic             lvl;
  logic             rise;
  logic             fall;

  uart_lw_framelen #(.CPB_W(CPB_W), .CNT_W(CNT_W)) u_len (
    .clk         (clk),
    .cpb_i       (clks_per_bit_i),
    .data_bits_i (data_bits_i),
    .parity_en_i (parity_en_i),
    .stop_sel_i  (stop_sel_i),
    .frame_len_o (frame_len)
  );

  uart_lw_level #(.SYNC_STAGES(SYNC_STAGES)) u_level (
    .clk      (clk),
    .rst      (rst),
    .line_i   (line_i),
    .invert_i (invert_i),
    .lvl_o    (lvl),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  uart_lw_break #(.CNT_W(CNT_W)) u_break (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (lvl),
    .rise_i      (rise),
    .fall_i      (fall),
    .frame_len_i (frame_len),
    .break_o     (break_o)
  );

  uart_lw_idle #(.CNT_W(CNT_W)) u_idle (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (lvl),
    .frame_len_i (frame_len),
    .hint_i      (frame_done_i),
    .age_i       (frame_age_i),
    .idle_o      (idle_o)
  );

  // R12
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(break_o && idle_o));

endmodule

// File: tb/uart_line_watch_test.sv
module uart_line_watch_test;

  localparam int CLK_PERIOD = 10;
  localparam int CPB_W      = 8;
  localparam int CNT_W      = CPB_W + 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             line = 1'b1;
  logic             invert = 1'b0;
  logic [CPB_W-1:0] cpb = 8'd4;
  logic [3:0]       dbits = 4'd8;
  logic             par = 1'b0;
  logic [1:0]       stop = 2'd2;
  logic             fdone = 1'b0;
  logic [CNT_W:0]   fage = '0;
  logic             break_o;
  logic             idle_o;

  uart_line_watch #(.CPB_W(CPB_W)) uut (
    .clk            (clk),
    .rst            (rst),
    .line_i         (line),
    .invert_i       (invert),
    .clks_per_bit_i (cpb),
    .data_bits_i    (dbits),
    .parity_en_i    (par),
    .stop_sel_i     (stop),
    .frame_done_i   (fdone),
    .frame_age_i    (fage),
    .break_o        (break_o),
    .idle_o         (idle_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    is_brk;
    string req;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   fails  = 0;
  int   flen   = 40;
  bit   done   = 1'b0;
  bit   prev_brk = 1'b0;
  bit   prev_idle = 1'b0;

  function automatic int model_len(int c, int d, int p, int s);
    int halves;
    halves = 2 * (1 + d + p) + s;
    return (c * halves + 1) / 2;
  endfunction

  function automatic string kname(bit b);
    return b ? "break" : "idle";
  endfunction

  task automatic push(int at, bit is_brk, string req);
    exp_t e;
    e.at = at; e.is_brk = is_brk; e.req = req;
    expq.push_back(e);
  endtask

  // Monitor: pops expected pulses as the design produces them.
  always @(negedge clk) begin
    if (!rst) begin
      while (expq.size() > 0 && expq[0].at < cyc) begin
        checks++; fails++;
        $display("FAIL %s: %s pulse missing at cycle %0d (actual none, expected pulse)",
                 expq[0].req, kname(expq[0].is_brk), expq[0].at);
        void'(expq.pop_front());
      end
      if (break_o && idle_o) begin
        checks++; fails++;
        $display("FAIL R12: both pulses at cycle %0d (actual 1/1, expected at most one)", cyc);
      end
      if ((break_o && prev_brk) || (idle_o && prev_idle)) begin
        checks++; fails++;
        $display("FAIL R12: pulse longer than one cycle at cycle %0d (actual 2 cycles, expected 1)", cyc);
      end
      if (break_o || idle_o) begin
        checks++;
        if (expq.size() > 0 && expq[0].at == cyc) begin
          if (expq[0].is_brk != break_o) begin
            fails++;
            $display("FAIL %s: cycle %0d actual %s, expected %s", expq[0].req, cyc,
                     kname(break_o), kname(expq[0].is_brk));
          end
          void'(expq.pop_front());
        end else begin
          fails++;
          $display("FAIL %s: unexpected %s pulse at cycle %0d (actual pulse, expected none, next due %0d)",
                   (expq.size() > 0) ? expq[0].req : "R12", kname(break_o), cyc,
                   (expq.size() > 0) ? expq[0].at : -1);
        end
      end
    end
    prev_brk  = break_o;
    prev_idle = idle_o;
  end

  // Driver: one line segment of n clocks at a logical level, pushing the
  // pulses it must cause. A segment is always followed by the other level.
  task automatic seg(bit lvl, int n, string req, bit hint_at_start = 1'b0);
    int n0;
    @(negedge clk);
    line = lvl ^ invert;
    n0 = cyc;
    if (hint_at_start) begin
      fdone = 1'b1;
      fage  = '0;
    end
    if (lvl) begin
      for (int j = 1; flen * j <= n; j++) push(n0 + 2 + flen * j, 1'b0, req);
    end else if (n >= flen) begin
      push(n0 + n + 3, 1'b1, req);
    end
    repeat (n - 1) begin
      @(negedge clk);
      fdone = 1'b0;
    end
  endtask

  // High segment with a frame-end hint sampled at edge n0+n_pre+1.
  task automatic hint_seg(int n_pre, int age, int n_post, string req);
    int n0, h, n1, v, p;
    @(negedge clk);
    line = 1'b1 ^ invert;
    n0 = cyc;
    h  = n0 + n_pre + 1;
    n1 = n0 + n_pre + n_post;
    p  = n0 + 2 + flen;
    while (p < h) begin
      push(p, 1'b0, req);
      p += flen;
    end
    v = 2 * flen - age;
    if (v < 1) v = 1;
    p = h + v;
    while (p <= n1 + 2) begin
      push(p, 1'b0, req);
      p += flen;
    end
    repeat (n_pre - 1) @(negedge clk);
    @(negedge clk);
    fdone = 1'b1;
    fage  = (CNT_W+1)'(age);
    @(negedge clk);
    fdone = 1'b0;
    repeat (n_post - 2) @(negedge clk);
  endtask

  task automatic phase(int c, int d, int p, int s, bit inv, int n0, string req);
    int rel;
    @(negedge clk);
    rst = 1'b1;
    if (expq.size() != 0) begin
      checks++; fails++;
      $display("FAIL %s: %0d pulses still due before reset (expected 0)", expq[0].req, expq.size());
      expq.delete();
    end
    cpb = CPB_W'(c); dbits = 4'(d); par = p[0]; stop = 2'(s); invert = inv;
    line = 1'b1 ^ inv;
    flen = model_len(c, d, p, s);
    repeat (4) @(negedge clk);
    checks++;
    if (break_o || idle_o) begin
      fails++;
      $display("FAIL R1: outputs during reset actual %b%b, expected 00", break_o, idle_o);
    end
    rst = 1'b0;
    rel = cyc;
    for (int j = 1; flen * j <= n0 + 2; j++) push(rel + flen * j, 1'b0, req);
    repeat (n0 - 1) @(negedge clk);
  endtask

  initial begin
    // Format A: L = 40
    phase(4, 8, 0, 2, 1'b0, 100, "R1");
    seg(0, 40, "R3");  seg(1, 30, "R3");
    seg(0, 39, "R4");  seg(1, 10, "R4");
    seg(0, 20, "R5");  seg(1, 1, "R5");  seg(0, 25, "R5");
    seg(1, 85, "R7");
    seg(0, 20, "R8");  seg(1, 30, "R8");  seg(0, 5, "R8");  seg(1, 45, "R8");
    seg(0, 41, "R3");  seg(1, 20, "R3");
    // R2: parity plus 1.5 stop bits, L = 53 (52.5 rounded up)
    phase(5, 7, 1, 3, 1'b0, 10, "R2");
    seg(0, 53, "R2");  seg(1, 52, "R2");  seg(0, 52, "R2");  seg(1, 110, "R2");
    seg(0, 3, "R2");   seg(1, 10, "R2");
    // R2: half stop bit, L = 20 (19.5 rounded up)
    phase(3, 5, 0, 1, 1'b0, 10, "R2");
    seg(0, 20, "R2");  seg(1, 19, "R2");  seg(0, 19, "R2");  seg(1, 45, "R2");
    seg(0, 3, "R2");   seg(1, 10, "R2");
    // R2: no stop bit, 9 data bits with parity, L = 33
    phase(3, 9, 1, 0, 1'b0, 10, "R2");
    seg(0, 33, "R2");  seg(1, 70, "R2");  seg(0, 32, "R2");  seg(1, 10, "R2");
    // R6: L = 1000, low period beyond the timer range
    phase(100, 8, 0, 2, 1'b0, 10, "R6");
    seg(0, 9000, "R6"); seg(1, 1000, "R6"); seg(0, 5, "R6"); seg(1, 10, "R6");
    // R9: inverted line, L = 40
    phase(4, 8, 0, 2, 1'b1, 50, "R9");
    seg(0, 40, "R9");  seg(1, 80, "R9");  seg(0, 10, "R9");  seg(1, 10, "R9");
    // R10 / R11: frame-end hint, L = 40
    phase(4, 8, 0, 2, 1'b0, 10, "R10");
    seg(0, 5, "R10");  hint_seg(20, 50, 100, "R10");
    seg(0, 5, "R10");  hint_seg(41, 10, 100, "R10");
    seg(0, 5, "R10");  hint_seg(10, 100, 50, "R10");
    seg(0, 5, "R10");  hint_seg(30, 0, 100, "R10");
    seg(0, 30, "R11"); seg(1, 45, "R11", 1'b1);
    seg(0, 3, "R11");  seg(1, 10, "R11");
    repeat (10) @(negedge clk);
    if (expq.size() != 0) begin
      checks++; fails++;
      $display("FAIL %s: %0d pulses never seen (expected 0 outstanding)", expq[0].req, expq.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end (actual timeout, expected completion)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule